// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between on-chip logic and an external asynchronous static RAM. The RAM has a 17-bit address and an 8-bit bidirectional data bus. It has two chip selects of opposite polarity, an active-low output enable and an active-low write enable. A client raises a request with a direction bit, an address and write data. The controller grants the request only when it is idle. It then plays out the pin-level cycle, using a clock-cycle count for each timing interval, and reports completion. A read returns its data with a one-cycle valid pulse. A write ends with a one-cycle done pulse.

Every interval is a parameter in clock cycles. Each one is the ceiling of the nanosecond minimum divided by the clock period, and never less than one. A write always ends on the rising edge of write enable while both selects are still active. The data bus is driven only after the RAM's output turn-off time has passed. Between accesses the RAM is deselected and the bus is released. The RAM needs no refresh, so the controller keeps it in standby.

The data pin is split into an output, an output-enable and an input. The pad tristate is built outside this block.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and between accesses, the first select (active low) is high and the second select (active high) is low. Write enable and output enable are both high and the data bus is not driven. The two selects are always at opposite levels.
- R2: `gnt_o` is high only when the controller is idle and `req_i` is high. A request held high during an access is not granted until the access and its turnaround have finished.
- R3: A read keeps the RAM selected, with output enable low and write enable high, for exactly RD_CYC cycles. The bus is sampled on the last of those cycles. `rvalid_o` pulses for one cycle, RD_CYC+1 clock edges after the accepting edge.
- R4: After a read the controller stays deselected for OE_HZ_CYC cycles before it can accept the next request. With a request held high, reads are therefore accepted every RD_CYC+OE_HZ_CYC+1 cycles.
- R5: A write holds write enable low for exactly WE_HZ_CYC+WD_SU_CYC cycles. Both selects stay active and output enable stays high throughout.
- R6: During the first WE_HZ_CYC cycles of write enable low, the data bus is not driven. It is then driven with stable write data for the last WD_SU_CYC cycles of write enable low.
- R7: The write ends when write enable rises while both selects are active. Address and data stay driven and unchanged for that one cycle. In the next cycle the RAM is deselected and the bus is released.
- R8: `wdone_o` pulses for one cycle, WE_HZ_CYC+WD_SU_CYC+2 edges after the accepting edge. With a request held high, writes are accepted every WE_HZ_CYC+WD_SU_CYC+2 cycles.
- R9: The controller never drives the data bus while output enable is low.
- R10: The RAM address is stable for as long as the RAM stays selected.
- R11: A byte written to an address is returned by a later read of that address, and each address keeps its own byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Request address |
| wdata_i | input | DW | Write data |
| gnt_o | output | 1 | Request accepted this cycle |
| rdata_o | output | DW | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle |
| wdone_o | output | 1 | Write finished, one cycle |
| ram_addr_o | output | AW | RAM address pins |
| ram_dq_o | output | DW | Data toward the RAM |
| ram_dq_oe_o | output | 1 | Drive enable for the data pins |
| ram_dq_i | input | DW | Data from the RAM pins |
| ram_cs1_no | output | 1 | First select, active low |
| ram_cs2_o | output | 1 | Second select, active high |
| ram_oe_no | output | 1 | Output enable, active low |
| ram_we_no | output | 1 | Write enable, active low |

## Verification
The following rules are checked on every cycle:
- the opposite polarity of the two selects;
- no drive while output enable is low;
- no drive on the cycle write enable falls;
- selects held through write-enable low and through its rising edge;
- address and data stability while selected or driven;
- the one-cycle width of both pulses.

Only the bench scenarios can show the interval lengths and the response latencies. The same holds for capture on the last read cycle, which the bench proves with a RAM model whose data is valid only on that cycle. Write-then-read integrity across every address, and acceptance spacing under held requests, are also shown only by the bench.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RTURN, ST_WHZ, ST_WDAT, ST_WEND
  } st_e;

  // internal strobes, active high
  typedef struct packed {
    logic sel;
    logic oe;
    logic we;
    logic drive;
  } strobe_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC    = 5,
  parameter int OE_HZ_CYC = 2,
  parameter int WE_HZ_CYC = 2,
  parameter int WD_SU_CYC = 2,
  parameter int CW        = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output strobe_t       strobe_o,
  output logic          gnt_o,
  output logic          cap_o,
  output logic          wfin_o
);
  st_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        tmr_load_o = 1'b1;
        if (we_i) begin
          st_d      = ST_WHZ;
          tmr_val_o = CW'(WE_HZ_CYC - 1);
        end else begin
          st_d      = ST_RD;
          tmr_val_o = CW'(RD_CYC - 1);
        end
      end
      ST_RD: if (tmr_zero_i) begin
        st_d       = ST_RTURN;
        tmr_load_o = 1'b1;
        tmr_val_o  = CW'(OE_HZ_CYC - 1);
      end
      ST_RTURN: if (tmr_zero_i) st_d = ST_IDLE;
      ST_WHZ: if (tmr_zero_i) begin
        st_d       = ST_WDAT;
        tmr_load_o = 1'b1;
        tmr_val_o  = CW'(WD_SU_CYC - 1);
      end
      ST_WDAT: if (tmr_zero_i) st_d = ST_WEND;
      ST_WEND: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes decode from the state flop only
  always_comb begin
    strobe_o.sel   = (st_q == ST_RD) || (st_q == ST_WHZ) || (st_q == ST_WDAT) || (st_q == ST_WEND);
    strobe_o.oe    = (st_q == ST_RD);
    strobe_o.we    = (st_q == ST_WHZ) || (st_q == ST_WDAT);
    strobe_o.drive = (st_q == ST_WDAT) || (st_q == ST_WEND);
  end

  assign gnt_o  = (st_q == ST_IDLE) && req_i;
  assign cap_o  = (st_q == ST_RD) && tmr_zero_i;
  assign wfin_o = (st_q == ST_WEND);
endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          gnt_i,
  input  logic          cap_i,
  input  logic          wfin_i,
  input  strobe_t       strobe_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] ram_dq_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          wdone_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe_o,
  output logic          ram_cs1_no,
  output logic          ram_cs2_o,
  output logic          ram_oe_no,
  output logic          ram_we_no
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q, wdone_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (gnt_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      wdone_q  <= 1'b0;
    end else begin
      if (cap_i) rdata_q <= ram_dq_i;
      rvalid_q <= cap_i;
      wdone_q  <= wfin_i;
    end
  end

  assign rdata_o     = rdata_q;
  assign rvalid_o    = rvalid_q;
  assign wdone_o     = wdone_q;
  assign ram_addr_o  = addr_q;
  assign ram_dq_o    = wdata_q;
  assign ram_dq_oe_o = strobe_i.drive;
  assign ram_cs1_no  = ~strobe_i.sel;
  assign ram_cs2_o   = strobe_i.sel;
  assign ram_oe_no   = ~strobe_i.oe;
  assign ram_we_no   = ~strobe_i.we;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int RD_CYC    = 5,  // read cycle / address access
  parameter int OE_HZ_CYC = 2,  // output turn-off after OE rises
  parameter int WE_HZ_CYC = 2,  // output turn-off after WE falls
  parameter int WD_SU_CYC = 2   // data setup to WE rise
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          gnt_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          wdone_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe_o,
  input  logic [DW-1:0] ram_dq_i,
  output logic          ram_cs1_no,
  output logic          ram_cs2_o,
  output logic          ram_oe_no,
  output logic          ram_we_no
);
  localparam int MAX_CYC = max4(RD_CYC, OE_HZ_CYC, WE_HZ_CYC, WD_SU_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);

  if (RD_CYC < 1 || OE_HZ_CYC < 1 || WE_HZ_CYC < 1 || WD_SU_CYC < 1) begin : g_bad_cfg
    $error("sram_ctrl: every interval must be at least one cycle");
  end

  logic          tmr_load, tmr_zero, cap, wfin;
  logic [CW-1:0] tmr_val;
  strobe_t       strobe;

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sram_ctrl_seq #(
    .RD_CYC(RD_CYC), .OE_HZ_CYC(OE_HZ_CYC), .WE_HZ_CYC(WE_HZ_CYC),
    .WD_SU_CYC(WD_SU_CYC), .CW(CW)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .strobe_o   (strobe),
    .gnt_o      (gnt_o),
    .cap_o      (cap),
    .wfin_o     (wfin)
  );

  sram_ctrl_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_i       (gnt_o),
    .cap_i       (cap),
    .wfin_i      (wfin),
    .strobe_i    (strobe),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .ram_dq_i    (ram_dq_i),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .wdone_o     (wdone_o),
    .ram_addr_o  (ram_addr_o),
    .ram_dq_o    (ram_dq_o),
    .ram_dq_oe_o (ram_dq_oe_o),
    .ram_cs1_no  (ram_cs1_no),
    .ram_cs2_o   (ram_cs2_o),
    .ram_oe_no   (ram_oe_no),
    .ram_we_no   (ram_we_no)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          gnt_o,
  input logic          rvalid_o,
  input logic          wdone_o,
  input logic [AW-1:0] ram_addr_o,
  input logic [DW-1:0] ram_dq_o,
  input logic          ram_dq_oe_o,
  input logic          ram_cs1_no,
  input logic          ram_cs2_o,
  input logic          ram_oe_no,
  input logic          ram_we_no
);
  a_r1_select_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_cs1_no == !ram_cs2_o);

  a_r2_grant_when_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o |-> (ram_cs1_no && ram_we_no && ram_oe_no && !ram_dq_oe_o));

  a_r3_rvalid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  a_r4_turnaround_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_oe_no) |-> (ram_cs1_no && !gnt_o && !ram_dq_oe_o));

  a_r5_write_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> (!ram_cs1_no && ram_cs2_o && ram_oe_no));

  a_r6_no_drive_at_we_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_we_no) |-> !ram_dq_oe_o);

  a_r6_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_dq_oe_o && $past(ram_dq_oe_o)) |-> $stable(ram_dq_o));

  a_r7_write_end_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_no) |-> (!ram_cs1_no && ram_cs2_o && ram_dq_oe_o && $stable(ram_addr_o)));

  a_r8_wdone_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdone_o |=> !wdone_o);

  a_r9_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> ram_oe_no);

  a_r10_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_cs1_no && $past(!ram_cs1_no)) |-> $stable(ram_addr_o));
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gnt_o       (gnt_o),
  .rvalid_o    (rvalid_o),
  .wdone_o     (wdone_o),
  .ram_addr_o  (ram_addr_o),
  .ram_dq_o    (ram_dq_o),
  .ram_dq_oe_o (ram_dq_oe_o),
  .ram_cs1_no  (ram_cs1_no),
  .ram_cs2_o   (ram_cs2_o),
  .ram_oe_no   (ram_oe_no),
  .ram_we_no   (ram_we_no)
);

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int RD_CYC    = 4;
  localparam int OE_HZ_CYC = 2;
  localparam int WE_HZ_CYC = 2;
  localparam int WD_SU_CYC = 3;
  localparam int NADDR = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic gnt, rvalid, wdone, dq_oe, cs1_n, cs2, oe_n, we_n;
  logic [DW-1:0] rdata, dq_out, dq_in;
  logic [AW-1:0] ram_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl #(
    .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .OE_HZ_CYC(OE_HZ_CYC),
    .WE_HZ_CYC(WE_HZ_CYC), .WD_SU_CYC(WD_SU_CYC)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .gnt_o(gnt), .rdata_o(rdata), .rvalid_o(rvalid),
    .wdone_o(wdone), .ram_addr_o(ram_addr), .ram_dq_o(dq_out),
    .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_in), .ram_cs1_no(cs1_n),
    .ram_cs2_o(cs2), .ram_oe_no(oe_n), .ram_we_no(we_n)
  );

  // RAM model: read data valid only on the last cycle of the read interval
  logic [DW-1:0] mem [NADDR];
  int rd_age = 0;
  wire ram_sel = !cs1_n && cs2;
  wire ram_rd  = ram_sel && !oe_n && we_n;
  assign dq_in = (ram_rd && rd_age == RD_CYC - 1) ? mem[ram_addr] : 8'hA5;

  always @(posedge clk) rd_age <= ram_rd ? rd_age + 1 : 0;
  always @(posedge we_n) if (ram_sel) mem[ram_addr] <= dq_oe ? dq_out : 8'h3C;

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req_tag, act, exp, cyc);
    end
  endtask

  // protocol monitor
  int we_run = 0, drv_run = 0, oe_run = 0;
  logic [AW-1:0] wr_addr;
  logic prev_we_n = 1'b1, prev_oe_n = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!we_n) begin
        if (we_run == 0) wr_addr = ram_addr;
        we_run++;
        if (dq_oe) drv_run++;
        if (dq_oe && we_run <= WE_HZ_CYC)
          check(1'b0, "R6 drive during turn-off", we_run, WE_HZ_CYC + 1);
      end else if (!prev_we_n) begin
        check(we_run == WE_HZ_CYC + WD_SU_CYC, "R5 we low length", we_run, WE_HZ_CYC + WD_SU_CYC);
        check(drv_run == WD_SU_CYC, "R6 data setup length", drv_run, WD_SU_CYC);
        check(ram_sel && dq_oe && ram_addr == wr_addr, "R7 end cycle held", {ram_sel, dq_oe}, 3);
        we_run = 0;
        drv_run = 0;
      end
      if (!oe_n) oe_run++;
      else if (!prev_oe_n) begin
        check(oe_run == RD_CYC, "R3 oe low length", oe_run, RD_CYC);
        oe_run = 0;
      end
      if (dq_oe && !oe_n) check(1'b0, "R9 bus contention", 1, 0);
      if (ram_sel && !oe_n && !we_n) check(1'b0, "R5 oe during write", 0, 1);
      prev_we_n = we_n;
      prev_oe_n = oe_n;
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [DW-1:0] pat1(input int a);
    return DW'((a * 37 + 5) & 8'hFF);
  endfunction
  function automatic logic [DW-1:0] pat2(input int a);
    return DW'(a ^ 8'h5A);
  endfunction

  task automatic access(input bit w, input int a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; addr = AW'(a); wdata = d;
    while (!gnt) @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!(w ? wdone : rvalid) && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    rd = rdata;
    if (!w) begin
      @(negedge clk);
      check(!rvalid, "R3 rvalid one cycle", rvalid, 0);
    end else begin
      check(cs1_n && !cs2 && !dq_oe, "R7 deselect after write", {cs1_n, cs2, dq_oe}, 4);
      @(negedge clk);
      check(!wdone, "R8 wdone one cycle", wdone, 0);
    end
  endtask

  initial begin
    logic [DW-1:0] rd;
    int lat;
    int g[3];
    repeat (3) @(negedge clk);
    check(cs1_n && !cs2 && we_n && oe_n && !dq_oe && !gnt, "R1 reset quiet",
          {cs1_n, cs2, we_n, oe_n, dq_oe}, 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs1_n && !cs2 && we_n && oe_n && !dq_oe, "R1 idle after reset",
          {cs1_n, cs2, we_n, oe_n, dq_oe}, 5'b10110);

    // R11: fill every address
    for (int a = 0; a < NADDR; a++) begin
      access(1'b1, a, pat1(a), rd, lat);
      if (a < 4) check(lat == WE_HZ_CYC + WD_SU_CYC + 2, "R8 wdone latency", lat, WE_HZ_CYC + WD_SU_CYC + 2);
    end
    for (int a = 0; a < NADDR; a++) begin
      access(1'b0, a, '0, rd, lat);
      check(rd == pat1(a), "R11 readback pass 1", rd, pat1(a));
      if (a < 4) check(lat == RD_CYC + 1, "R3 rvalid latency", lat, RD_CYC + 1);
    end
    for (int a = 0; a < NADDR; a += 2) access(1'b1, a, pat2(a), rd, lat);
    for (int a = NADDR - 1; a >= 0; a--) begin
      access(1'b0, a, '0, rd, lat);
      check(rd == ((a % 2 == 0) ? pat2(a) : pat1(a)), "R11 readback pass 2",
            rd, (a % 2 == 0) ? pat2(a) : pat1(a));
    end
    check(cs1_n && !cs2 && we_n && oe_n && !dq_oe, "R1 idle between accesses",
          {cs1_n, cs2, we_n, oe_n, dq_oe}, 5'b10110);

    // R2/R4: held read request, acceptance spacing
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'd17;
    for (int k = 0; k < 3; k++) begin
      while (!gnt) begin
        @(negedge clk);
        if (!cs1_n) check(!gnt, "R2 no grant while busy", gnt, 0);
      end
      g[k] = cyc;
      @(negedge clk);
    end
    req = 1'b0;
    check(g[1] - g[0] == RD_CYC + OE_HZ_CYC + 1, "R4 read spacing", g[1] - g[0], RD_CYC + OE_HZ_CYC + 1);
    check(g[2] - g[1] == RD_CYC + OE_HZ_CYC + 1, "R4 read spacing", g[2] - g[1], RD_CYC + OE_HZ_CYC + 1);
    repeat (RD_CYC + OE_HZ_CYC + 2) @(negedge clk);

    // R8: held write request spacing, then verify
    req = 1'b1; we = 1'b1; addr = 8'd200; wdata = 8'hE7;
    for (int k = 0; k < 3; k++) begin
      while (!gnt) @(negedge clk);
      g[k] = cyc;
      @(negedge clk);
    end
    req = 1'b0;
    check(g[1] - g[0] == WE_HZ_CYC + WD_SU_CYC + 2, "R8 write spacing", g[1] - g[0], WE_HZ_CYC + WD_SU_CYC + 2);
    check(g[2] - g[1] == WE_HZ_CYC + WD_SU_CYC + 2, "R8 write spacing", g[2] - g[1], WE_HZ_CYC + WD_SU_CYC + 2);
    repeat (WE_HZ_CYC + WD_SU_CYC + 3) @(negedge clk);
    access(1'b0, 200, '0, rd, lat);
    check(rd == 8'hE7, "R11 held write data", rd, 8'hE7);
    access(1'b0, 201, '0, rd, lat);
    check(rd == pat1(201), "R11 neighbour untouched", rd, pat1(201));

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule